// File: doc/BRIEF.md
# Rotate-and-Mask Insert Unit

This unit takes a source register, rotates it left, and merges it into an insert-target register under a contiguous bit mask. The mask is built from a begin index and an end index. When the begin index is past the end index, the mask wraps around the word. Bit positions use big-endian numbering: index 0 is the most significant bit of the 64-bit word. The result is `(rotated & mask) | (target & ~mask)`. Driving the target with zero gives a plain rotate-and-mask.

Two modes are supported. In word mode the low 32 bits of the source are copied into both halves before the rotate. The rotate amount is then 5 bits, and both mask bounds are 5-bit fields offset by 32. In doubleword mode the rotate amount is 6 bits. The mask begin is a 6-bit field stored with its bits permuted, and the mask end is 63 minus the rotate amount. The carry output is always zero.

Operands enter through a valid/ready handshake and the result leaves through a second one. There is one register stage. An operand is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high while the output stage is empty or is being drained in the same cycle (`out_ready` high). A result presented with `out_valid` stays unchanged until `out_ready` takes it. Back-pressure on the output therefore stalls the input after one buffered item.

Top module: `rmi_unit`

## Requirements
- R1: In doubleword mode (`in_word`=0) the source is rotated left by the 6-bit `in_amt`, and an amount of 0 leaves it unrotated. With `in_amt`=0 and `in_mb`=0 the mask covers all 64 bits and the result equals `in_src`.
- R2: In word mode (`in_word`=1) the rotated value is `{src[31:0],src[31:0]}` rotated left by `in_amt[4:0]`. `in_amt[5]` has no effect.
- R3: When the mask start is less than or equal to the mask end, mask bits are set at big-endian indices start through end inclusive. Big-endian index i is vector bit 63-i.
- R4: When the mask start exceeds the mask end, mask bits are set at big-endian indices start through 63 and 0 through end.
- R5: In word mode the mask start is `in_mb[4:0]`+32 and the mask end is `in_me[4:0]`+32. `in_mb[5]` and `in_me[5]` have no effect.
- R6: In doubleword mode the mask start is `{in_mb[0], in_mb[5:1]}` and the mask end is 63 minus `in_amt`. `in_me` has no effect.
- R7: Result bits outside the mask come from `in_ins`, and bits inside the mask come from the rotated source.
- R8: `out_carry` is 0 on every transfer.
- R9: An operand accepted at one edge is presented with `out_valid` high after that edge. `in_ready` is low while `out_valid` is high and `out_ready` is low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` hold their values to the next cycle.
- R11: During reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set valid |
| in_ready | output | 1 | Unit can accept an operand set |
| in_src | input | 64 | Register to rotate |
| in_ins | input | 64 | Insert target, used outside the mask |
| in_amt | input | 6 | Rotate amount |
| in_mb | input | 6 | Mask begin field |
| in_me | input | 6 | Mask end field (word mode only) |
| in_word | input | 1 | 1 = word mode, 0 = doubleword mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_result | output | 64 | Merged result |
| out_carry | output | 1 | Carry out, always 0 |

## Verification
The checker watches the handshake on every cycle. It confirms that an accepted operand shows up as valid output on the next cycle and that a stalled result neither drops nor changes. It confirms that input readiness falls under output back-pressure. It also checks the identity case: a zero doubleword rotate with a zero begin field returns the source. The data behaviours need the bench scenarios, because each one depends on a particular combination of fields. These are word-mode duplication, the ignored upper field bits, the permuted begin field, wrapped masks and the merge with a nonzero target. The bench runs directed cases for each of them and then randomised operands under random back-pressure.

// File: rtl/rmi_pkg.sv
package rmi_pkg;
  localparam int unsigned RMI_W = 64;

  typedef enum logic {
    MODE_DWORD = 1'b0,
    MODE_WORD  = 1'b1
  } rmi_mode_e;
endpackage

// File: rtl/rmi_bounds.sv
module rmi_bounds #(
  parameter int unsigned W = rmi_pkg::RMI_W,
  localparam int unsigned AW = $clog2(W),
  localparam int unsigned HW = W / 2
) (
  input  logic          word,
  input  logic [AW-1:0] amt,
  input  logic [AW-1:0] mb,
  input  logic [AW-1:0] me,
  output logic [AW-1:0] start_idx,
  output logic [AW-1:0] end_idx
);
  localparam logic [AW-1:0] HALF = AW'(HW);
  localparam logic [AW-1:0] TOP  = AW'(W - 1);

  always_comb begin
    if (rmi_pkg::rmi_mode_e'(word) == rmi_pkg::MODE_WORD) begin
      start_idx = {1'b0, mb[AW-2:0]} + HALF;
      end_idx   = {1'b0, me[AW-2:0]} + HALF;
    end else begin
      start_idx = {mb[0], mb[AW-1:1]};
      end_idx   = TOP - amt;
    end
  end
endmodule

// File: rtl/rmi_rotator.sv
module rmi_rotator #(
  parameter int unsigned W = rmi_pkg::RMI_W,
  localparam int unsigned AW = $clog2(W),
  localparam int unsigned HW = W / 2
) (
  input  logic [W-1:0]  data,
  input  logic [AW-1:0] amt,
  input  logic          word,
  output logic [W-1:0]  rot
);
  logic [W-1:0]   src_x;
  logic [AW:0]    sh;
  logic [AW:0]    rsh;
  logic [2*W-1:0] dbl;
  logic [2*W-1:0] shifted;

  always_comb begin
    src_x   = word ? {data[HW-1:0], data[HW-1:0]} : data;
    sh      = word ? {2'b00, amt[AW-2:0]} : {1'b0, amt};
    rsh     = (AW+1)'(W) - sh;
    dbl     = {src_x, src_x};
    shifted = dbl >> rsh;
    rot     = shifted[W-1:0];
  end
endmodule

// File: rtl/rmi_maskgen.sv
module rmi_maskgen #(
  parameter int unsigned W = rmi_pkg::RMI_W,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [AW-1:0] start_idx,
  input  logic [AW-1:0] end_idx,
  output logic [W-1:0]  mask
);
  logic wraps;
  assign wraps = start_idx > end_idx;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [AW-1:0] BE = AW'(i);
    logic ge_s, le_e;
    assign ge_s = BE >= start_idx;
    assign le_e = BE <= end_idx;
    assign mask[W-1-i] = wraps ? (ge_s | le_e) : (ge_s & le_e);
  end
endmodule

// File: rtl/rmi_unit.sv
module rmi_unit #(
  parameter int unsigned W = rmi_pkg::RMI_W,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_src,
  input  logic [W-1:0]  in_ins,
  input  logic [AW-1:0] in_amt,
  input  logic [AW-1:0] in_mb,
  input  logic [AW-1:0] in_me,
  input  logic          in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_result,
  output logic          out_carry
);
  logic [AW-1:0] start_idx, end_idx;
  logic [W-1:0]  rot, mask, merged;
  logic          fire;

  rmi_bounds #(.W(W)) u_bounds (
    .word(in_word), .amt(in_amt), .mb(in_mb), .me(in_me),
    .start_idx(start_idx), .end_idx(end_idx)
  );

  rmi_rotator #(.W(W)) u_rot (
    .data(in_src), .amt(in_amt), .word(in_word), .rot(rot)
  );

  rmi_maskgen #(.W(W)) u_mask (
    .start_idx(start_idx), .end_idx(end_idx), .mask(mask)
  );

  assign merged    = (rot & mask) | (in_ins & ~mask);
  assign in_ready  = !out_valid || out_ready;
  assign fire      = in_valid && in_ready;
  assign out_carry = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= merged;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/rmi_unit_chk.sv
module rmi_unit_chk #(
  parameter int unsigned W = rmi_pkg::RMI_W,
  localparam int unsigned AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_src,
  input logic [AW-1:0] in_amt,
  input logic [AW-1:0] in_mb,
  input logic          in_word,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_result
);
  // R9: an accepted operand is presented on the next cycle
  assert_accept_to_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: output back-pressure blocks the input
  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: a stalled result keeps its valid flag
  assert_stall_holds_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R10: a stalled result keeps its data
  assert_stall_holds_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_result));

  // R1: zero doubleword rotate with zero begin field returns the source
  assert_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_amt == '0 && !in_word && in_mb == '0)
      |=> out_result == $past(in_src));
endmodule

bind rmi_unit rmi_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_src(in_src), .in_amt(in_amt), .in_mb(in_mb), .in_word(in_word),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
);

// File: tb/rmi_unit_bench.sv
module rmi_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [63:0] in_ins = '0;
  logic [5:0]  in_amt = '0;
  logic [5:0]  in_mb = '0;
  logic [5:0]  in_me = '0;
  logic        in_word = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_carry;

  int checks = 0;
  int errors = 0;
  bit random_ready = 1'b0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  rmi_unit u_rmi_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_ins(in_ins), .in_amt(in_amt), .in_mb(in_mb),
    .in_me(in_me), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_carry(out_carry)
  );

  function automatic logic [63:0] model(input logic [63:0] src, input logic [63:0] ins,
                                        input logic [5:0] amt, input logic [5:0] mb,
                                        input logic [5:0] me, input logic word);
    logic [63:0] x, rot, msk;
    int sh, s, e;
    if (word) begin
      x = {src[31:0], src[31:0]};
      sh = int'(amt[4:0]);
      s = int'(mb[4:0]) + 32;
      e = int'(me[4:0]) + 32;
    end else begin
      x = src;
      sh = int'(amt);
      s = int'({mb[0], mb[5:1]});
      e = 63 - int'(amt);
    end
    rot = (sh == 0) ? x : ((x << sh) | (x >> (64 - sh)));
    msk = '0;
    for (int i = 0; i < 64; i++) begin
      if ((s <= e) ? (i >= s && i <= e) : (i >= s || i <= e)) msk[63 - i] = 1'b1;
    end
    return (rot & msk) | (ins & ~msk);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called just after a falling edge
  task automatic send(input logic [63:0] src, input logic [63:0] ins, input logic [5:0] amt,
                      input logic [5:0] mb, input logic [5:0] me, input logic word,
                      input string tag);
    in_src = src; in_ins = ins; in_amt = amt; in_mb = mb; in_me = me; in_word = word;
    in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    exp_q.push_back(model(src, ins, amt, mb, me, word));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: drives back-pressure and compares transfers
  initial begin
    forever begin
      @(negedge clk);
      out_ready = random_ready ? (($urandom % 4) != 0) : 1'b1;
      #3;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected output", out_result, '0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_result === e, t, out_result, e);
          check(out_carry === 1'b0, "R8 carry", {63'd0, out_carry}, '0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check(out_valid === 1'b0, "R11 out_valid in reset", {63'd0, out_valid}, '0);
    check(in_ready === 1'b1, "R11 in_ready in reset", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    send(64'h0123_4567_89AB_CDEF, '0, 6'd0, 6'd0, 6'd0, 1'b0, "R1 identity");
    send(64'h0123_4567_89AB_CDEF, '0, 6'd4, 6'd0, 6'd0, 1'b0, "R1 rotate by 4");
    send(64'h8000_0000_0000_0001, '0, 6'd63, 6'd0, 6'd0, 1'b0, "R1 rotate by 63");
    send(64'hFFFF_0000_DEAD_BEEF, '0, 6'd8, 6'd0, 6'd31, 1'b1, "R2 word rotate 8");
    send(64'hFFFF_0000_DEAD_BEEF, '0, 6'd40, 6'd0, 6'd31, 1'b1, "R2 amt bit 5 ignored");
    send(64'h1234_5678_9ABC_DEF0, '0, 6'd20, 6'd20, 6'd0, 1'b0, "R3 start 10 end 43");
    send(64'hFFFF_FFFF_FFFF_FFFF, '0, 6'd0, 6'd5, 6'd20, 1'b1, "R3 word start 37 end 52");
    send(64'hFFFF_FFFF_FFFF_FFFF, '0, 6'd0, 6'd20, 6'd5, 1'b1, "R4 word wrap 52 to 37");
    send(64'hFFFF_FFFF_FFFF_FFFF, '0, 6'd60, 6'd1, 6'd0, 1'b0, "R4 dword wrap 32 to 3");
    send(64'hCAFE_F00D_1357_9BDF, '0, 6'd3, 6'd35, 6'd60, 1'b1, "R5 upper field bits ignored");
    send(64'hCAFE_F00D_1357_9BDF, '0, 6'd9, 6'd7, 6'd11, 1'b0, "R6 me ignored A");
    send(64'hCAFE_F00D_1357_9BDF, '0, 6'd9, 6'd7, 6'd50, 1'b0, "R6 me ignored B");
    send(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd12, 6'd16, 6'd0, 1'b0, "R7 target outside mask");
    send(64'hA5A5_A5A5_5A5A_5A5A, 64'h1111_2222_3333_4444, 6'd7, 6'd10, 6'd3, 1'b1, "R7 word insert");

    random_ready = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [63:0] s, t;
      s = {$urandom, $urandom};
      t = (n % 3 == 0) ? 64'd0 : {$urandom, $urandom};
      send(s, t, 6'($urandom), 6'($urandom), 6'($urandom), 1'($urandom),
           "R10 random under back-pressure");
    end

    while (exp_q.size() != 0) @(negedge clk);
    random_ready = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule